// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Code Unit for an 8-bit Memory Word

This block protects one 8-bit memory word with a Hamming code plus one overall parity bit. On the write side, a data byte enters with a valid strobe. One clock later a 13-bit word appears, ready to store. Inside that word the four check bits sit at the power-of-two positions of a 12-bit interleaved layout, and the thirteenth bit makes the parity of the whole word even.

On the read side, a 13-bit word taken from storage enters with its own valid strobe. The block recomputes the check bits from the data field and XORs them with the stored ones to form the syndrome. For any single flipped bit the syndrome equals that bit's position number, so the block can flip it back. The overall parity then tells a single error (parity odd) from a double error (parity even). One clock later the block returns the corrected byte, a corrected-error flag, an uncorrectable-error flag and the syndrome.

The two paths are independent and may be used in the same cycle. Each path has a single register stage.

Top module: `ecc_secded_top`

## Requirements
- R1: `enc_word_o` bit p-1 holds code position p, for p = 1..12. Check bits C1, C2, C4 and C8 sit at positions 1, 2, 4 and 8. Data bits D1..D8 (`wr_data_i[0]`..`wr_data_i[7]`) sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. The check bits are: C1 = D1^D2^D4^D5^D7, C2 = D1^D3^D4^D6^D7, C4 = D2^D3^D4^D8 and C8 = D5^D6^D7^D8. Bit 12 makes the XOR of all 13 bits zero. Example: data 8'h39 gives word 13'h134F.
- R2: `enc_valid_o` is high exactly in the cycle after a cycle with `wr_valid_i` high, and `enc_word_o` then carries that data's code. While `wr_valid_i` is low, `enc_word_o` holds its value.
- R3: `dec_syndrome_o` is the stored check bits XOR the recomputed check bits, with bit 0 = C1, bit 1 = C2, bit 2 = C4 and bit 3 = C8. For a single flipped bit at position 1..12, it equals that position. Example: flipping D3 gives 4'b0110.
- R4: A word with no error returns its data field, with both flags low and a zero syndrome.
- R5: A single flipped data bit is corrected in `dec_data_o`, and `dec_sec_o` is raised.
- R6: A single flipped check bit (positions 1, 2, 4 or 8) leaves the data unchanged and raises `dec_sec_o`.
- R7: A flipped parity bit (bit 12) gives a zero syndrome, correct data and `dec_sec_o` high.
- R8: A nonzero syndrome with even overall parity raises `dec_ded_o` only. In that case `dec_data_o` is the uncorrected data field.
- R9: A syndrome of 13 to 15 with odd overall parity raises `dec_ded_o` only. In that case `dec_data_o` is the uncorrected data field.
- R10: `dec_valid_o` is high exactly in the cycle after a cycle with `rd_valid_i` high. While `rd_valid_i` is low, the decode outputs hold their values.
- R11: While `rst_ni` is low, every output is zero.
- R12: `dec_sec_o` and `dec_ded_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write data strobe |
| wr_data_i | input | 8 | Data byte to encode |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_word_o | output | 13 | Encoded word: Hamming bits [11:0], overall parity [12] |
| rd_valid_i | input | 1 | Read word strobe |
| rd_word_i | input | 13 | Word read back from storage |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 8 | Corrected data byte |
| dec_sec_o | output | 1 | Single error found and corrected |
| dec_ded_o | output | 1 | Uncorrectable error found |
| dec_syndrome_o | output | 4 | Syndrome, bit 0 = C1 |

## Verification
A wrong check-bit equation shows in the next cycle in two ways: the written word differs from the bench model, and a clean word read back yields a nonzero syndrome together with a false double-error flag. A wrong position map or a wrong flip decode shows at `dec_data_o` in the cycle after the read. The sweep of single flips over all 13 bit positions exposes it at the first position that is mishandled. A wrong classification shows the same cycle as a swapped or missing flag. Syndromes 13 to 15 and the parity-bit-only flip are driven directly, so that they are not left to chance.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  // smallest k with 2^k - 1 >= m + k
  function automatic int chk_bits(int m);
    int k;
    k = 1;
    while (((1 << k) - 1) < (m + k)) k++;
    return k;
  endfunction

  function automatic bit is_pow2(int p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  // data index held at non-power-of-two position p
  function automatic int data_idx(int p);
    return p - $clog2(p) - 1;
  endfunction

  typedef enum logic [1:0] {
    DEC_CLEAN = 2'd0,
    DEC_FIX   = 2'd1,
    DEC_UNFIX = 2'd2
  } dec_kind_e;

endpackage

// File: rtl/ecc_check_gen.sv
module ecc_check_gen #(
  parameter  int DATA_W = 8,
  localparam int CHK_W  = ecc_pkg::chk_bits(DATA_W),
  localparam int HAM_W  = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);

  logic [HAM_W-1:0] placed;

  for (genvar p = 1; p <= HAM_W; p++) begin : g_place
    if (ecc_pkg::is_pow2(p)) begin : g_chk
      assign placed[p-1] = 1'b0;
    end else begin : g_dat
      assign placed[p-1] = data_i[ecc_pkg::data_idx(p)];
    end
  end

  function automatic logic [HAM_W-1:0] sel_mask(int j);
    logic [HAM_W-1:0] m;
    for (int p = 1; p <= HAM_W; p++) m[p-1] = ((p >> j) & 1) != 0;
    return m;
  endfunction

  for (genvar j = 0; j < CHK_W; j++) begin : g_chk
    assign chk_o[j] = ^(placed & sel_mask(j));
  end

endmodule

// File: rtl/ecc_encoder.sv
module ecc_encoder #(
  parameter  int DATA_W = 8,
  localparam int CHK_W  = ecc_pkg::chk_bits(DATA_W),
  localparam int HAM_W  = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [HAM_W:0]    word_o
);

  logic [CHK_W-1:0] chk;

  ecc_check_gen #(.DATA_W(DATA_W)) u_gen (
    .data_i (data_i),
    .chk_o  (chk)
  );

  for (genvar p = 1; p <= HAM_W; p++) begin : g_pos
    if (ecc_pkg::is_pow2(p)) begin : g_chk
      assign word_o[p-1] = chk[$clog2(p)];
    end else begin : g_dat
      assign word_o[p-1] = data_i[ecc_pkg::data_idx(p)];
    end
  end

  assign word_o[HAM_W] = ^word_o[HAM_W-1:0];

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder #(
  parameter  int DATA_W = 8,
  localparam int CHK_W  = ecc_pkg::chk_bits(DATA_W),
  localparam int HAM_W  = DATA_W + CHK_W
) (
  input  logic [HAM_W:0]    word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sec_o,
  output logic              ded_o,
  output logic [CHK_W-1:0]  syn_o
);

  logic [DATA_W-1:0] raw_data;
  logic [DATA_W-1:0] fix_data;
  logic [CHK_W-1:0]  stored_chk;
  logic [CHK_W-1:0]  calc_chk;
  logic [HAM_W-1:0]  flip;
  logic [HAM_W-1:0]  fixed;
  logic              par_fail;
  logic              do_flip;
  ecc_pkg::dec_kind_e kind;

  for (genvar p = 1; p <= HAM_W; p++) begin : g_pos
    if (ecc_pkg::is_pow2(p)) begin : g_chk
      assign stored_chk[$clog2(p)] = word_i[p-1];
    end else begin : g_dat
      assign raw_data[ecc_pkg::data_idx(p)] = word_i[p-1];
      assign fix_data[ecc_pkg::data_idx(p)] = fixed[p-1];
    end
    assign flip[p-1] = do_flip && (syn_o == CHK_W'(p));
  end

  ecc_check_gen #(.DATA_W(DATA_W)) u_gen (
    .data_i (raw_data),
    .chk_o  (calc_chk)
  );

  assign syn_o    = stored_chk ^ calc_chk;
  assign par_fail = ^word_i;

  always_comb begin
    if (syn_o == '0)             kind = par_fail ? ecc_pkg::DEC_FIX : ecc_pkg::DEC_CLEAN;
    else if (!par_fail)          kind = ecc_pkg::DEC_UNFIX;
    else if (int'(syn_o) > HAM_W) kind = ecc_pkg::DEC_UNFIX;
    else                         kind = ecc_pkg::DEC_FIX;
  end

  assign do_flip = (kind == ecc_pkg::DEC_FIX) && (syn_o != '0);
  assign fixed   = word_i[HAM_W-1:0] ^ flip;
  assign data_o  = fix_data;
  assign sec_o   = (kind == ecc_pkg::DEC_FIX);
  assign ded_o   = (kind == ecc_pkg::DEC_UNFIX);

endmodule

// File: rtl/ecc_secded_top.sv
module ecc_secded_top #(
  parameter  int DATA_W = 8,
  localparam int CHK_W  = ecc_pkg::chk_bits(DATA_W),
  localparam int WORD_W = DATA_W + CHK_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              enc_valid_o,
  output logic [WORD_W-1:0] enc_word_o,
  input  logic              rd_valid_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dec_sec_o,
  output logic              dec_ded_o,
  output logic [CHK_W-1:0]  dec_syndrome_o
);

  logic [WORD_W-1:0] enc_word_d;
  logic [DATA_W-1:0] dec_data_d;
  logic              dec_sec_d;
  logic              dec_ded_d;
  logic [CHK_W-1:0]  dec_syn_d;

  ecc_encoder #(.DATA_W(DATA_W)) u_enc (
    .data_i (wr_data_i),
    .word_o (enc_word_d)
  );

  ecc_decoder #(.DATA_W(DATA_W)) u_dec (
    .word_i (rd_word_i),
    .data_o (dec_data_d),
    .sec_o  (dec_sec_d),
    .ded_o  (dec_ded_d),
    .syn_o  (dec_syn_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_valid_o <= 1'b0;
      enc_word_o  <= '0;
    end else begin
      enc_valid_o <= wr_valid_i;
      if (wr_valid_i) enc_word_o <= enc_word_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o    <= 1'b0;
      dec_data_o     <= '0;
      dec_sec_o      <= 1'b0;
      dec_ded_o      <= 1'b0;
      dec_syndrome_o <= '0;
    end else begin
      dec_valid_o <= rd_valid_i;
      if (rd_valid_i) begin
        dec_data_o     <= dec_data_d;
        dec_sec_o      <= dec_sec_d;
        dec_ded_o      <= dec_ded_d;
        dec_syndrome_o <= dec_syn_d;
      end
    end
  end

endmodule

// File: rtl/ecc_secded_chk.sv
module ecc_secded_chk #(
  parameter  int DATA_W = 8,
  localparam int CHK_W  = ecc_pkg::chk_bits(DATA_W),
  localparam int WORD_W = DATA_W + CHK_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              enc_valid_o,
  input logic [WORD_W-1:0] enc_word_o,
  input logic              rd_valid_i,
  input logic              dec_valid_o,
  input logic [DATA_W-1:0] dec_data_o,
  input logic              dec_sec_o,
  input logic              dec_ded_o,
  input logic [CHK_W-1:0]  dec_syndrome_o
);

  assert_enc_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> enc_valid_o);

  assert_enc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> !enc_valid_o && $stable(enc_word_o));

  assert_enc_even_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_o |-> !(^enc_word_o));

  assert_dec_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> dec_valid_o);

  assert_dec_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> !dec_valid_o && $stable(dec_data_o) && $stable(dec_syndrome_o)
                    && $stable(dec_sec_o) && $stable(dec_ded_o));

  assert_flags_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_sec_o && dec_ded_o));

  assert_zero_syn_no_ded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_syndrome_o == '0) |-> !dec_ded_o);

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R11: assert (!enc_valid_o && enc_word_o == '0 && !dec_valid_o &&
                                dec_data_o == '0 && !dec_sec_o && !dec_ded_o &&
                                dec_syndrome_o == '0);
    end
  end

endmodule

bind ecc_secded_top ecc_secded_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_valid_i     (wr_valid_i),
  .enc_valid_o    (enc_valid_o),
  .enc_word_o     (enc_word_o),
  .rd_valid_i     (rd_valid_i),
  .dec_valid_o    (dec_valid_o),
  .dec_data_o     (dec_data_o),
  .dec_sec_o      (dec_sec_o),
  .dec_ded_o      (dec_ded_o),
  .dec_syndrome_o (dec_syndrome_o)
);

// File: tb/sim_ecc_secded_top.sv
`timescale 1ns/1ps
module sim_ecc_secded_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic        enc_valid_o;
  logic [12:0] enc_word_o;
  logic        rd_valid_i = 1'b0;
  logic [12:0] rd_word_i = '0;
  logic        dec_valid_o;
  logic [7:0]  dec_data_o;
  logic        dec_sec_o;
  logic        dec_ded_o;
  logic [3:0]  dec_syndrome_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  ecc_secded_top u0 (
    .clk_i, .rst_ni, .wr_valid_i, .wr_data_i, .enc_valid_o, .enc_word_o,
    .rd_valid_i, .rd_word_i, .dec_valid_o, .dec_data_o, .dec_sec_o,
    .dec_ded_o, .dec_syndrome_o
  );

  function automatic logic [12:0] b_encode(input logic [7:0] d);
    logic c1, c2, c4, c8;
    logic [12:0] w;
    c1 = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c2 = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c4 = d[1] ^ d[2] ^ d[3] ^ d[7];
    c8 = d[4] ^ d[5] ^ d[6] ^ d[7];
    w[11:0] = {d[7], d[6], d[5], d[4], c8, d[3], d[2], d[1], c4, d[0], c2, c1};
    w[12] = ^w[11:0];
    return w;
  endfunction

  function automatic logic [7:0] b_extract(input logic [12:0] w);
    return {w[11], w[10], w[9], w[8], w[6], w[5], w[4], w[2]};
  endfunction

  function automatic logic [3:0] b_syn(input logic [12:0] w);
    logic [3:0] s = '0;
    for (int p = 1; p <= 12; p++) if (w[p-1]) s ^= 4'(p);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d, input string req);
    logic [12:0] e;
    e = b_encode(d);
    wr_data_i = d;
    wr_valid_i = 1'b1;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    wr_data_i = ~d;
    chk(enc_valid_o == 1'b1, {req, " R2 valid"}, 32'(enc_valid_o), 32'd1);
    chk(enc_word_o == e, {req, " R1 word"}, 32'(enc_word_o), 32'(e));
  endtask

  // full-requirement expectation for a read word
  task automatic do_read(input logic [12:0] w, input string req);
    logic [3:0] s;
    logic pf, e_sec, e_ded;
    logic [12:0] f;
    logic [7:0] e_data;
    s = b_syn(w);
    pf = ^w;
    f = w;
    e_sec = 1'b0;
    e_ded = 1'b0;
    if (s == 0) e_sec = pf;
    else if (!pf || s > 12) e_ded = 1'b1;
    else begin
      e_sec = 1'b1;
      f[s-1] = ~f[s-1];
    end
    e_data = b_extract(f);
    rd_word_i = w;
    rd_valid_i = 1'b1;
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    rd_word_i = ~w;
    chk(dec_valid_o == 1'b1, {req, " R10 valid"}, 32'(dec_valid_o), 32'd1);
    chk(dec_syndrome_o == s, {req, " R3 syndrome"}, 32'(dec_syndrome_o), 32'(s));
    chk(dec_data_o == e_data, {req, " data"}, 32'(dec_data_o), 32'(e_data));
    chk({dec_sec_o, dec_ded_o} == {e_sec, e_ded}, {req, " flags R12"},
        32'({dec_sec_o, dec_ded_o}), 32'({e_sec, e_ded}));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [12:0] w;
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    // R11: reset state
    chk({enc_valid_o, enc_word_o, dec_valid_o, dec_data_o, dec_sec_o, dec_ded_o, dec_syndrome_o} == '0,
        "R11 reset", 32'({enc_valid_o, dec_valid_o, dec_sec_o, dec_ded_o}), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 test vector
    do_write(8'h39, "R1 vector");
    chk(enc_word_o == 13'h134F, "R1 literal", 32'(enc_word_o), 32'h134F);
    // R2: hold while idle
    w = enc_word_o;
    @(negedge clk_i);
    chk(enc_valid_o == 1'b0, "R2 idle valid", 32'(enc_valid_o), 32'd0);
    chk(enc_word_o == w, "R2 hold word", 32'(enc_word_o), 32'(w));

    // R4 clean, R3/R5 D3 flip
    do_read(13'h134F, "R4 clean");
    chk(dec_data_o == 8'h39 && !dec_sec_o && !dec_ded_o, "R4 clean direct",
        32'(dec_data_o), 32'h39);
    do_read(13'h134F ^ 13'h0020, "R5 D3 flip");
    chk(dec_syndrome_o == 4'b0110, "R3 syndrome six", 32'(dec_syndrome_o), 32'h6);
    chk(dec_data_o == 8'h39 && dec_sec_o, "R5 corrected", 32'(dec_data_o), 32'h39);
    // R10: hold on idle read
    @(negedge clk_i);
    chk(!dec_valid_o && dec_data_o == 8'h39 && dec_syndrome_o == 4'd6, "R10 hold",
        32'(dec_syndrome_o), 32'd6);

    // R5 R6 R7: sweep single flips over every position
    for (int b = 0; b < 13; b++) begin
      d = 8'hA6;
      w = b_encode(d) ^ (13'd1 << b);
      do_read(w, "R5 R6 R7 sweep");
      chk(dec_data_o == d && dec_sec_o && !dec_ded_o, "R5 R6 R7 single corrected",
          32'({dec_data_o, dec_sec_o, dec_ded_o}), 32'({d, 2'b10}));
    end
    // R7: parity bit only
    do_read(b_encode(8'h5C) ^ 13'h1000, "R7 parity bit");
    chk(dec_syndrome_o == 0 && dec_sec_o && dec_data_o == 8'h5C, "R7 parity direct",
        32'(dec_data_o), 32'h5C);

    // R8: double error, data raw
    w = b_encode(8'h39) ^ 13'h0004 ^ 13'h0010;
    do_read(w, "R8 double");
    chk(dec_ded_o && !dec_sec_o && dec_data_o == b_extract(w), "R8 raw data",
        32'(dec_data_o), 32'(b_extract(w)));

    // R9: syndromes 13..15 with odd parity
    w = b_encode(8'h00) ^ 13'h0001 ^ 13'h0008 ^ 13'h0080;
    do_read(w, "R9 syn13");
    chk(dec_syndrome_o == 4'd13 && dec_ded_o && !dec_sec_o, "R9 syn13 ded",
        32'(dec_syndrome_o), 32'd13);
    w = b_encode(8'hFF) ^ 13'h0002 ^ 13'h0008 ^ 13'h0080;
    do_read(w, "R9 syn14");
    chk(dec_syndrome_o == 4'd14 && dec_ded_o && dec_data_o == b_extract(w), "R9 syn14 ded",
        32'(dec_data_o), 32'(b_extract(w)));
    w = b_encode(8'h81) ^ 13'h0004 ^ 13'h0008 ^ 13'h0080;
    do_read(w, "R9 syn15");
    chk(dec_syndrome_o == 4'd15 && dec_ded_o, "R9 syn15 ded", 32'(dec_syndrome_o), 32'd15);

    // random round trips with 0, 1 or 2 flips
    for (int i = 0; i < 300; i++) begin
      int nf, b1, b2;
      d = 8'($urandom);
      do_write(d, "R1 random");
      w = enc_word_o;
      nf = int'($urandom % 3);
      b1 = int'($urandom % 13);
      b2 = (b1 + 1 + int'($urandom % 12)) % 13;
      if (nf >= 1) w[b1] = ~w[b1];
      if (nf == 2) w[b2] = ~w[b2];
      do_read(w, "R4 R5 R8 random");
      if (nf < 2)
        chk(dec_data_o == d && dec_sec_o == (nf == 1) && !dec_ded_o, "R4 R5 random round trip",
            32'(dec_data_o), 32'(d));
      else
        chk(dec_ded_o && !dec_sec_o, "R8 random double", 32'({dec_sec_o, dec_ded_o}), 32'b01);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule